// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block runs a 512-pixel linear light sensor that reads out serially. It drives the sensor's two digital inputs: a divided sensor clock and a single start pulse. It also tells a downstream analog-to-digital converter the moment to sample each pixel. The block works entirely in the system clock domain. It derives the sensor clock from a programmable half-period, which is clamped so the sensor clock never goes above the sensor's 5 MHz limit.

Each frame starts when the start line is high for exactly one sensor-clock rising edge. The block then counts 512 pixel edges and issues the extra terminating edge. It raises a frame-done pulse on that terminating edge. The gap before the next frame sets the exposure: the block inserts a programmable number of idle sensor clocks before it starts again. In continuous mode the next frame follows automatically. In single-shot mode the block waits for a trigger. The sensor's end-of-sequence output can optionally be compared against the edge count, and a mismatch sets a sticky error.

Top module: `linscan_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, sens_clk, sens_si, pix_stb, frame_done and so_err are 0 and pix_idx is 0.
- R2: Each high phase and each low phase of sens_clk lasts max(cfg_half, 10) system clock cycles. The floor of 10 comes from the 100 MHz system clock and the 5 MHz sensor limit.
- R3: sens_si changes only in the system cycle in which sens_clk falls. sens_si is high at exactly one rising edge of sens_clk per frame, and that edge is counted as frame edge 1.
- R4: pix_stb pulses exactly 512 times per frame, once per pixel. For pixel N (1..512), the pulse falls in the last system cycle of the high phase that follows frame edge N, and pix_idx reads N-1 during the pulse, so the index runs 0 to 511 in ascending order.
- R5: frame_done is a one-cycle pulse. It occurs in the system cycle in which sens_clk rises for the 513th time in the frame, and it never coincides with pix_stb.
- R6: In continuous mode (cfg_cont=1), edge 1 of the next frame is the edge numbered 514+cfg_idle of the current frame. That is cfg_idle+1 sensor rising edges after the edge that carried frame_done.
- R7: In single-shot mode (cfg_cont=0), a trig pulse starts one frame. Without a trig, sens_si stays low and no frame begins.
- R8: With cfg_so_chk=1, the block samples sens_so at the end of each high phase in a frame. The expected value is high after frame edge 512 and low after edges 1..511. Any mismatch sets so_err, which stays set until reset. The 513th edge and frame_done are still issued.
- R9: With cfg_so_chk=0, sens_so is ignored and so_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half | input | HALF_W (8) | Requested sensor clock half-period in system cycles, clamped at the minimum |
| cfg_idle | input | IDLE_W (16) | Idle sensor clocks inserted between frames (exposure) |
| cfg_cont | input | 1 | 1 = restart frames automatically, 0 = single-shot |
| cfg_so_chk | input | 1 | Enable the end-of-sequence consistency check |
| trig | input | 1 | Single-shot frame request pulse |
| sens_so | input | 1 | End-of-sequence output from the sensor |
| sens_clk | output | 1 | Sensor clock |
| sens_si | output | 1 | Sensor start pulse |
| pix_idx | output | log2(N_PIX) (9) | Index of the pixel being strobed, 0..511 |
| pix_stb | output | 1 | Converter sample strobe, one per pixel |
| frame_done | output | 1 | Pulse on the terminating edge of a frame |
| so_err | output | 1 | Sticky end-of-sequence mismatch flag |

## Verification
The sensor clock and the frame outputs are registered together, so each result is due at a fixed offset. frame_done appears in the same system cycle as the 513th sens_clk rise. Each pix_stb appears in the last system cycle of a high phase, eff system cycles after the rise. so_err is due by the cycle after the fall that follows edge 512, which is well before frame_done. The bench samples on the falling system clock and keeps a small sensor model driven by sens_clk. It counts high-phase cycles and sensor edges independently, so each check compares a count (high-phase length, edge number, strobe position, gap in edges) against the value the requirement fixes. Flags are read only after the frame_done pulse.

// File: rtl/linscan_pkg.sv
// Shared types and elaboration-time helpers for the readout sequencer.
// Assumes frequencies are given in Hz and fit a 64-bit integer.
package linscan_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // waiting for a start condition
        FS_ARM  = 2'd1,   // start pulse raised, waiting for the rising edge
        FS_READ = 2'd2,   // pixel edges 1..512 in progress
        FS_GAP  = 2'd3    // idle exposure clocks after the terminating edge
    } fs_t;

    // Smallest legal half-period in system cycles, never below 2.
    function automatic int half_floor(longint sys_hz, longint max_hz);
        longint h;
        h = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (h < 2) ? 2 : int'(h);
    endfunction

endpackage

// File: rtl/linscan_clkgen.sv
// Sensor clock divider. It keeps the sensor clock as a registered level
// in the system domain and raises single-cycle event strobes one cycle
// before each edge and two cycles before a fall.
// Assumes MIN_HALF >= 2 and that it fits HALF_W bits.
module linscan_clkgen #(
    parameter int HALF_W   = 8,
    parameter int MIN_HALF = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] cfg_half,
    output logic              sclk_o,
    output logic              rise_evt,
    output logic              fall_evt,
    output logic              late_hi
);
    localparam logic [HALF_W-1:0] MIN_H = HALF_W'(MIN_HALF);

    logic [HALF_W-1:0] eff_half;
    logic [HALF_W-1:0] cnt_q;
    logic              sclk_q;
    logic              wrap;

    // Clamp the requested half-period to the sensor's frequency limit.
    always_comb begin
        eff_half = (cfg_half < MIN_H) ? MIN_H : cfg_half;
    end

    assign wrap = (cnt_q >= (eff_half - HALF_W'(1)));

    // Phase counter and sensor clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + HALF_W'(1);
        end
    end

    assign sclk_o   = sclk_q;
    assign rise_evt = wrap & ~sclk_q;
    assign fall_evt = wrap &  sclk_q;
    assign late_hi  = sclk_q & (cnt_q == (eff_half - HALF_W'(2)));

endmodule

// File: rtl/linscan_frame.sv
// Frame sequencer. It raises the start pulse on a sensor clock fall,
// counts edges 1..512, issues a strobe late in each pixel's high phase,
// ends the frame on the 513th edge and then waits cfg_idle rising edges
// before it restarts (continuous) or waits for a trigger (single-shot).
// Assumes the event strobes come from linscan_clkgen and never overlap.
module linscan_frame
    import linscan_pkg::*;
#(
    parameter int N_PIX  = 512,
    parameter int IDLE_W = 16,
    localparam int IDX_W  = $clog2(N_PIX),
    localparam int ECNT_W = $clog2(N_PIX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              late_hi,
    input  logic [IDLE_W-1:0] cfg_idle,
    input  logic              cfg_cont,
    input  logic              trig,
    output logic              si_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              stb_o,
    output logic              done_o,
    output logic              in_read,
    output logic [ECNT_W-1:0] ecnt_o
);
    localparam logic [ECNT_W-1:0] LAST_PIX = ECNT_W'(N_PIX);

    fs_t               st_q;
    logic              si_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic [IDLE_W-1:0] gcnt_q;
    logic              pend_q;
    logic              stb_q;
    logic              done_q;
    logic [IDX_W-1:0]  idx_q;
    logic              go;

    assign go = cfg_cont | pend_q;

    // Frame state, edge counting, start pulse and per-pixel outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FS_IDLE;
            si_q   <= 1'b0;
            ecnt_q <= '0;
            gcnt_q <= '0;
            pend_q <= 1'b0;
            stb_q  <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            stb_q  <= 1'b0;
            done_q <= 1'b0;
            if (trig && !cfg_cont) begin
                pend_q <= 1'b1;
            end
            case (st_q)
                FS_IDLE: begin
                    if (fall_evt && go) begin
                        si_q   <= 1'b1;
                        pend_q <= 1'b0;
                        st_q   <= FS_ARM;
                    end
                end
                FS_ARM: begin
                    if (rise_evt) begin
                        ecnt_q <= ECNT_W'(1);
                        st_q   <= FS_READ;
                    end
                end
                FS_READ: begin
                    if (fall_evt) begin
                        si_q <= 1'b0;
                    end
                    if (late_hi) begin
                        stb_q <= 1'b1;
                        idx_q <= IDX_W'(ecnt_q - ECNT_W'(1));
                    end
                    if (rise_evt) begin
                        if (ecnt_q == LAST_PIX) begin
                            done_q <= 1'b1;
                            ecnt_q <= '0;
                            gcnt_q <= '0;
                            st_q   <= FS_GAP;
                        end else begin
                            ecnt_q <= ecnt_q + ECNT_W'(1);
                        end
                    end
                end
                FS_GAP: begin
                    if (rise_evt) begin
                        gcnt_q <= gcnt_q + IDLE_W'(1);
                    end else if (fall_evt && (gcnt_q >= cfg_idle)) begin
                        if (go) begin
                            si_q   <= 1'b1;
                            pend_q <= 1'b0;
                            st_q   <= FS_ARM;
                        end else begin
                            st_q   <= FS_IDLE;
                        end
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    assign si_o    = si_q;
    assign idx_o   = idx_q;
    assign stb_o   = stb_q;
    assign done_o  = done_q;
    assign in_read = (st_q == FS_READ);
    assign ecnt_o  = ecnt_q;

    // R3
    si_one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_READ && rise_evt) |-> !si_q);

endmodule

// File: rtl/linscan_socheck.sv
// End-of-sequence consistency check. It synchronises the sensor's
// serial-out line and compares it at the end of every high phase inside
// a frame: high after edge 512, low after earlier edges. A mismatch sets
// a flag that holds until reset.
// Assumes sens_so settles well within one high phase.
module linscan_socheck #(
    parameter int N_PIX  = 512,
    localparam int ECNT_W = $clog2(N_PIX + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sens_so,
    input  logic              fall_evt,
    input  logic              in_read,
    input  logic [ECNT_W-1:0] ecnt,
    output logic              err_o
);
    localparam logic [ECNT_W-1:0] LAST_PIX = ECNT_W'(N_PIX);

    logic so_s1_q;
    logic so_s2_q;
    logic err_q;
    logic so_exp;

    assign so_exp = (ecnt == LAST_PIX);

    // Two-stage synchroniser for the sensor's serial-out line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_s1_q <= 1'b0;
            so_s2_q <= 1'b0;
        end else begin
            so_s1_q <= sens_so;
            so_s2_q <= so_s1_q;
        end
    end

    // Sticky mismatch flag, compared once per high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (enable && in_read && fall_evt && (so_s2_q != so_exp)) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/linscan_ctrl.sv
// Top of the linear sensor readout sequencer. It ties the clock divider,
// the frame sequencer and the end-of-sequence check together, and holds
// the cross-module timing checks.
// Assumes all inputs are synchronous to clk, except sens_so.
module linscan_ctrl
    import linscan_pkg::*;
#(
    parameter longint SYS_HZ      = 100_000_000,
    parameter longint SCLK_MAX_HZ = 5_000_000,
    parameter int     N_PIX       = 512,
    parameter int     HALF_W      = 8,
    parameter int     IDLE_W      = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [HALF_W-1:0]        cfg_half,
    input  logic [IDLE_W-1:0]        cfg_idle,
    input  logic                     cfg_cont,
    input  logic                     cfg_so_chk,
    input  logic                     trig,
    input  logic                     sens_so,
    output logic                     sens_clk,
    output logic                     sens_si,
    output logic [$clog2(N_PIX)-1:0] pix_idx,
    output logic                     pix_stb,
    output logic                     frame_done,
    output logic                     so_err
);
    localparam int MIN_HALF = half_floor(SYS_HZ, SCLK_MAX_HZ);
    localparam int ECNT_W   = $clog2(N_PIX + 2);

    logic              rise_evt;
    logic              fall_evt;
    logic              late_hi;
    logic              in_read;
    logic [ECNT_W-1:0] ecnt;

    linscan_clkgen #(
        .HALF_W   (HALF_W),
        .MIN_HALF (MIN_HALF)
    ) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_half (cfg_half),
        .sclk_o   (sens_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .late_hi  (late_hi)
    );

    linscan_frame #(
        .N_PIX  (N_PIX),
        .IDLE_W (IDLE_W)
    ) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .late_hi  (late_hi),
        .cfg_idle (cfg_idle),
        .cfg_cont (cfg_cont),
        .trig     (trig),
        .si_o     (sens_si),
        .idx_o    (pix_idx),
        .stb_o    (pix_stb),
        .done_o   (frame_done),
        .in_read  (in_read),
        .ecnt_o   (ecnt)
    );

    linscan_socheck #(
        .N_PIX (N_PIX)
    ) socheck_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_so_chk),
        .sens_so  (sens_so),
        .fall_evt (fall_evt),
        .in_read  (in_read),
        .ecnt     (ecnt),
        .err_o    (so_err)
    );

    // Phase-length tracker used only by the divider-limit check.
    localparam logic [HALF_W:0] MIN_LEN = (HALF_W + 1)'(MIN_HALF);
    logic              sclk_prev_q;
    logic              ph_seen_q;
    logic [HALF_W:0]   ph_len_q;

    // Count system cycles since the last sensor clock change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            ph_seen_q   <= 1'b0;
            ph_len_q    <= '0;
        end else begin
            sclk_prev_q <= sens_clk;
            if (sens_clk != sclk_prev_q) begin
                ph_len_q  <= (HALF_W + 1)'(1);
                ph_seen_q <= 1'b1;
            end else if (ph_len_q != '1) begin
                ph_len_q  <= ph_len_q + (HALF_W + 1)'(1);
            end
        end
    end

    // R2
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_seen_q && (sens_clk != sclk_prev_q)) |-> (ph_len_q >= MIN_LEN));

    // R3
    si_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sens_si) |-> !sens_clk);

    // R4
    stb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> sens_clk);

    // R5
    done_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (sens_clk && !$past(sens_clk)));

    // R5
    done_not_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !pix_stb);

endmodule

// File: tb/linscan_ctrl_tb.sv
// Self-checking bench for linscan_ctrl with a behavioural sensor model.
module linscan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half = 8'd10;
    logic [15:0] cfg_idle = 16'd0;
    logic        cfg_cont = 1'b0;
    logic        cfg_so_chk = 1'b0;
    logic        trig = 1'b0;
    logic        sens_so;
    logic        sens_clk;
    logic        sens_si;
    logic [8:0]  pix_idx;
    logic        pix_stb;
    logic        frame_done;
    logic        so_err;

    always #5 clk = ~clk;

    linscan_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_half   (cfg_half),
        .cfg_idle   (cfg_idle),
        .cfg_cont   (cfg_cont),
        .cfg_so_chk (cfg_so_chk),
        .trig       (trig),
        .sens_so    (sens_so),
        .sens_clk   (sens_clk),
        .sens_si    (sens_si),
        .pix_idx    (pix_idx),
        .pix_stb    (pix_stb),
        .frame_done (frame_done),
        .so_err     (so_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Sensor model: token position after each edge, serial-out, edge counters.
    int       pos = 0;
    int       rise_total = 0;
    int       frame_rises = 0;
    int       si_rises = 0;
    int       si_seen = 0;
    int       si_at = 0;
    logic [1:0] so_fault = 2'd0;   // 0 normal, 1 stuck low, 2 stuck high

    always @(posedge sens_clk) begin
        rise_total++;
        frame_rises++;
        if (sens_si) begin
            pos = 1;
            frame_rises = 1;
            si_rises++;
            si_seen++;
            si_at = rise_total;
        end else if (pos != 0) begin
            if (pos >= 512) pos = 0;
            else pos++;
        end
    end

    assign sens_so = (so_fault == 2'd1) ? 1'b0 :
                     (so_fault == 2'd2) ? 1'b1 : (pos == 512);

    // Output monitor, sampled on the falling system clock.
    int   eff = 10;
    int   hi_cnt = 0;
    int   stb_cnt = 0;
    int   exp_idx = 0;
    int   done_cnt = 0;
    int   done_at = 0;
    logic prev_si = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hi_cnt  = 0;
            exp_idx = 0;
        end else begin
            if (sens_clk) begin
                hi_cnt++;
            end else begin
                if (hi_cnt != 0) chk(hi_cnt == eff, "R2 high phase length", hi_cnt, eff);
                hi_cnt = 0;
            end
            if (sens_si != prev_si) chk(!sens_clk, "R3 start pulse moves on low clock", sens_clk, 0);
            if (pix_stb) begin
                stb_cnt++;
                chk(int'(pix_idx) == exp_idx, "R4 pixel index", pix_idx, exp_idx);
                chk(pos == exp_idx + 1, "R4 strobe after edge N", pos, exp_idx + 1);
                chk(hi_cnt == eff, "R4 strobe in last high cycle", hi_cnt, eff);
                exp_idx++;
            end
            if (frame_done) begin
                done_cnt++;
                done_at = rise_total;
                chk(frame_rises == 513, "R5 done on edge 513", frame_rises, 513);
                chk(!pix_stb, "R5 done apart from strobe", pix_stb, 0);
                exp_idx = 0;
            end
        end
        prev_si = sens_si;
    end

    // Single-shot vector table.
    typedef struct packed {
        logic [7:0]  half;
        logic [15:0] idle;
        logic        chk_en;
        logic [1:0]  fault;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd10, 16'd0, 1'b1, 2'd0},   // nominal, check on
        '{8'd3,  16'd0, 1'b1, 2'd0},   // R2 clamp to floor
        '{8'd12, 16'd0, 1'b1, 2'd1},   // R8 serial-out missing
        '{8'd10, 16'd5, 1'b0, 2'd2},   // R9 check off, faulty line
        '{8'd11, 16'd2, 1'b1, 2'd0}    // odd half-period
    };

    task automatic wait_done(input int n, input string req);
        int guard = 0;
        while (done_cnt < n && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_cnt >= n, req, done_cnt, n);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        rst_n      = 1'b0;
        cfg_half   = v.half;
        cfg_idle   = v.idle;
        cfg_cont   = 1'b0;
        cfg_so_chk = v.chk_en;
        so_fault   = v.fault;
        eff        = (v.half < 8'd10) ? 10 : int'(v.half);
        repeat (3) @(negedge clk);
        stb_cnt  = 0;
        si_rises = 0;
        done_cnt = 0;
        rst_n    = 1'b1;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        wait_done(1, "R7 triggered frame completes");
        repeat (3) @(negedge clk);
        chk(stb_cnt == 512, "R4 strobes per frame", stb_cnt, 512);
        chk(si_rises == 1, "R3 one edge with start high", si_rises, 1);
        if (v.chk_en)
            chk(so_err == (v.fault != 2'd0), "R8 mismatch flag", so_err, int'(v.fault != 2'd0));
        else
            chk(so_err == 1'b0, "R9 check disabled", so_err, 0);
    endtask

    initial begin
        int si_before;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sens_clk == 0 && sens_si == 0 && pix_stb == 0 && frame_done == 0,
            "R1 outputs in reset", {sens_clk, sens_si, pix_stb, frame_done}, 0);
        chk(pix_idx == 0 && so_err == 0, "R1 index and flag in reset", {pix_idx, so_err}, 0);

        for (int i = 0; i < 5; i++) run_vec(VECS[i]);

        // R7: single-shot without trigger stays idle
        @(negedge clk) rst_n = 1'b0;
        cfg_half = 8'd10; cfg_idle = 16'd0; cfg_cont = 1'b0; cfg_so_chk = 1'b1; so_fault = 2'd0;
        eff = 10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        done_cnt = 0;
        si_before = si_seen;
        repeat (2000) @(negedge clk);
        chk(si_seen == si_before, "R7 no start without trig", si_seen - si_before, 0);
        chk(done_cnt == 0, "R7 no frame without trig", done_cnt, 0);

        // R6: continuous mode, gaps for two idle settings
        cfg_cont = 1'b1;
        wait_done(1, "R6 first continuous frame");
        si_before = si_seen;
        while (si_seen == si_before) @(negedge clk);
        chk(si_at - done_at == 1, "R6 gap with zero idle", si_at - done_at, 1);
        cfg_idle = 16'd3;
        wait_done(2, "R6 second continuous frame");
        si_before = si_seen;
        while (si_seen == si_before) @(negedge clk);
        chk(si_at - done_at == 4, "R6 gap with three idle", si_at - done_at, 4);
        cfg_cont = 1'b0;
        wait_done(3, "R7 frame after leaving continuous");
        si_before = si_seen;
        repeat (1000) @(negedge clk);
        chk(si_seen == si_before, "R7 no restart in single-shot", si_seen - si_before, 0);
        chk(so_err == 0, "R8 no mismatch on healthy sensor", so_err, 0);

        // R8 sticky, then R1 mid-run reset clears everything
        @(negedge clk) rst_n = 1'b0;
        so_fault = 2'd2; cfg_cont = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (600) @(negedge clk);
        chk(so_err == 1, "R8 flag set on stuck-high line", so_err, 1);
        so_fault = 2'd0;
        repeat (200) @(negedge clk);
        chk(so_err == 1, "R8 flag stays set", so_err, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sens_clk == 0 && sens_si == 0 && pix_stb == 0 && frame_done == 0 && so_err == 0,
            "R1 mid-run reset", {sens_clk, sens_si, pix_stb, frame_done, so_err}, 0);
        rst_n = 1'b1;
        cfg_cont = 1'b0;
        @(negedge clk);
        chk(pix_idx == 0 && so_err == 0, "R1 first cycle after reset", {pix_idx, so_err}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule